// File: doc/BRIEF.md
# Graphics command packet parser

This block sits between a 32-bit command word stream and a drawing back end. The top byte of the first word of each packet is the command code, and a computed length function gives how many parameter words follow it. The parser gathers all words of a packet into a local store, applies the packet's side effects to a status field and a set of environment registers, and then replays the packet word by word to the back end with first and last markers. While the back end stalls, the input is not accepted. A packet whose words arrive with gaps, or with input idle in the middle, is held until its last word arrives.

Two commands start a rectangle transfer with video memory: one writes to it and one reads from it. Neither is sent to the back end. Their two parameter words are the transfer position and size, and they are presented on a one-cycle start strobe. After a write start, the next ceil(width*height/2) input words go to the transfer data port instead of the parser, because each word carries two 16-bit pixels. Normal parsing then resumes. After a read start, parsing resumes at once.

The controller has five named states. IDLE waits for a command word. GATHER collects parameter words. FRAME is a single cycle that applies side effects and decides what comes next. EMIT replays the packet. XFER routes write data. The transitions are named as follows. IDLE→FRAME is taken on a command with no parameters. IDLE→GATHER is taken on any other command. GATHER→FRAME is taken when the last parameter is accepted. FRAME→EMIT is taken for ordinary commands. FRAME→XFER is taken for a write transfer with a non-zero word count. FRAME→IDLE is taken for a read transfer or an empty write transfer. EMIT→IDLE is taken when the last word is accepted downstream. XFER→IDLE is taken when the last data word is accepted.

Top module: `gpp_cmd_parser`

## Requirements
- R1: After reset, in_ready is 1, pkt_valid, xfer_start and xfer_wvalid are 0, status_bits is 0 and every environment register is 0.
- R2: A packet is 1 + N words long, where N depends on the command byte (word bits 31:24). N is 3 for 0x20-0x23, 6 for 0x24-0x27, 4 for 0x28-0x2B, 8 for 0x2C-0x2F, 5 for 0x30-0x33, 8 for 0x34-0x37, 7 for 0x38-0x3B and 11 for 0x3C-0x3F. N is 2 for 0x02, 3 for 0x80, 2 for 0xA0 and 2 for 0xC0, and 0 for every other code. Except for 0xA0 and 0xC0, every packet is forwarded in arrival order with pkt_first on word 0 and pkt_last on word N.
- R3: A partial packet is kept while in_valid is low for any number of cycles, and nothing is forwarded until its final word has been accepted.
- R4: While pkt_valid is 1 and pkt_ready is 0, pkt_data, pkt_first and pkt_last hold their values and in_ready is 0.
- R5: If (cmd & 0xF4) == 0x24, status_bits[8:0] takes bits 8:0 of word 4 of the packet, where word 0 is the command word. If (cmd & 0xF4) == 0x34, status_bits[8:0] takes bits 8:0 of word 5. The other status bits are kept. Status changes only in the cycle that frames a packet.
- R6: Command 0xE1 sets status_bits[10:0] to bits 10:0 of its word. Command 0xE6 sets status_bits[12:11] to bits 1:0 of its word.
- R7: Commands 0xE0-0xE7 store their whole word in environment register cmd[2:0]. Register k appears on env_regs[32k+31:32k]. No other command changes these registers.
- R8: dirty_mark is high for exactly one cycle for each framed packet whose command lies in 0x02..0xBF, and it stays low for all other commands.
- R9: For 0xA0 and 0xC0, xfer_start pulses for one cycle with xfer_pos = word 1, xfer_size = word 2 and xfer_read = 1 only for 0xC0. No word of the packet reaches the back end.
- R10: After 0xA0, width = size[15:0] and height = size[31:16]. The next ceil(width*height/2) accepted input words appear on xfer_wdata with xfer_wvalid. xfer_wlast is set on the last of them. When the count is 0, none are routed. The word after them is parsed as a command.
- R11: After 0xC0, the next input word is parsed as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command stream word valid |
| in_ready | output | 1 | Command stream word accepted |
| in_data | input | 32 | Command stream word |
| pkt_valid | output | 1 | Back-end word valid |
| pkt_ready | input | 1 | Back end accepts word |
| pkt_data | output | 32 | Forwarded packet word |
| pkt_first | output | 1 | Word is the command word |
| pkt_last | output | 1 | Word is the final packet word |
| dirty_mark | output | 1 | Frame buffer touched by framed packet |
| xfer_start | output | 1 | Rectangle transfer start strobe |
| xfer_read | output | 1 | Transfer direction, 1 = read from memory |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_wvalid | output | 1 | Transfer write data valid |
| xfer_wready | input | 1 | Transfer engine accepts data |
| xfer_wdata | output | 32 | Transfer write data |
| xfer_wlast | output | 1 | Final transfer write word |
| status_bits | output | 13 | Status field updated by packets |
| env_regs | output | 256 | Eight 32-bit environment registers |

## Verification
The bench builds the parser with its default parameters: a 12-word packet store, eight environment registers and a 32-bit transfer counter. With these defaults the longest packet (12 words) fills the store exactly, every 0xE0-0xE7 index selects a distinct register, and word counts such as 3 (from 3x2 pixels), 2 (from 3x1) and 0 (from zero height) can be checked against the end-of-transfer return to parsing. Each primitive group's length, the stall and idle-gap cases, and the order in which status updates from separate packets build on each other are driven as directed scenarios.

// File: rtl/gpp_pkg.sv
package gpp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_GATHER = 3'd1,
        ST_FRAME  = 3'd2,
        ST_EMIT   = 3'd3,
        ST_XFER   = 3'd4
    } state_e;

    localparam logic [7:0] CMD_VRAM_WR = 8'hA0;
    localparam logic [7:0] CMD_VRAM_RD = 8'hC0;
    localparam logic [7:0] CMD_DRAWMODE = 8'hE1;
    localparam logic [7:0] CMD_MASKSET  = 8'hE6;

    // Number of parameter words following a command word.
    function automatic logic [3:0] param_count(input logic [7:0] c);
        logic [3:0] n;
        if (c[7:5] == 3'b001) begin
            unique case (c[4:2])
                3'b000: n = 4'd3;
                3'b001: n = 4'd6;
                3'b010: n = 4'd4;
                3'b011: n = 4'd8;
                3'b100: n = 4'd5;
                3'b101: n = 4'd8;
                3'b110: n = 4'd7;
                default: n = 4'd11;
            endcase
        end else begin
            unique case (c)
                8'h02:       n = 4'd2;
                8'h80:       n = 4'd3;
                CMD_VRAM_WR: n = 4'd2;
                CMD_VRAM_RD: n = 4'd2;
                default:     n = 4'd0;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/gpp_pkt_store.sv
module gpp_pkt_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_idx,
    input  logic [DW-1:0]             wr_data,
    output logic [DEPTH-1:0][DW-1:0]  words_o
);

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_o[e] <= '0;
            end else if (wr_en && wr_idx == AW'(e)) begin
                words_o[e] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/gpp_side_fx.sv
module gpp_side_fx #(
    parameter int DW    = 32,
    parameter int ENV_N = 8,
    parameter int ST_W  = 13,
    localparam int IDX_W = $clog2(ENV_N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fire,
    input  logic [DW-1:0]           word0,
    input  logic [8:0]              word4_lo,
    input  logic [8:0]              word5_lo,
    output logic [ST_W-1:0]         status_o,
    output logic [ENV_N*DW-1:0]     env_o
);
    import gpp_pkg::*;

    logic [7:0] cmd;
    logic [ST_W-1:0] status_nx;

    assign cmd = word0[DW-1 -: 8];

    always_comb begin
        status_nx = status_o;
        if ((cmd & 8'hF4) == 8'h24) begin
            status_nx[8:0] = word4_lo;
        end else if ((cmd & 8'hF4) == 8'h34) begin
            status_nx[8:0] = word5_lo;
        end else if (cmd == CMD_DRAWMODE) begin
            status_nx[10:0] = word0[10:0];
        end else if (cmd == CMD_MASKSET) begin
            status_nx[12:11] = word0[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
        end else if (fire) begin
            status_o <= status_nx;
        end
    end

    for (genvar i = 0; i < ENV_N; i++) begin : g_env
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                env_o[i*DW +: DW] <= '0;
            end else if (fire && cmd[7:3] == 5'b11100 && cmd[IDX_W-1:0] == IDX_W'(i)) begin
                env_o[i*DW +: DW] <= word0;
            end
        end
    end

endmodule

// File: rtl/gpp_xfer_ctrl.sv
module gpp_xfer_ctrl #(
    parameter int XFER_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       size_word,
    input  logic              load,
    input  logic              step,
    output logic              empty_o,
    output logic              last_o
);

    logic [31:0]       area;
    logic [XFER_W-1:0] words;
    logic [XFER_W-1:0] remain;

    // Two 16-bit pixels per word, rounding up.
    always_comb begin
        area  = 32'(size_word[15:0]) * 32'(size_word[31:16]);
        words = XFER_W'(area[31:1]) + XFER_W'(area[0]);
    end

    assign empty_o = (words == '0);
    assign last_o  = (remain == XFER_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= words;
        end else if (step && remain != '0) begin
            remain <= remain - XFER_W'(1);
        end
    end

endmodule

// File: rtl/gpp_cmd_parser.sv
module gpp_cmd_parser #(
    parameter int PKT_MAX = 12,
    parameter int ENV_N   = 8,
    parameter int XFER_W  = 32,
    parameter int ST_W    = 13,
    localparam int DW     = 32,
    localparam int AW     = $clog2(PKT_MAX),
    localparam int CW     = $clog2(PKT_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [DW-1:0]        in_data,
    output logic                 pkt_valid,
    input  logic                 pkt_ready,
    output logic [DW-1:0]        pkt_data,
    output logic                 pkt_first,
    output logic                 pkt_last,
    output logic                 dirty_mark,
    output logic                 xfer_start,
    output logic                 xfer_read,
    output logic [DW-1:0]        xfer_pos,
    output logic [DW-1:0]        xfer_size,
    output logic                 xfer_wvalid,
    input  logic                 xfer_wready,
    output logic [DW-1:0]        xfer_wdata,
    output logic                 xfer_wlast,
    output logic [ST_W-1:0]      status_bits,
    output logic [ENV_N*DW-1:0]  env_regs
);
    import gpp_pkg::*;

    state_e state, state_nx;

    logic [CW-1:0]                held;
    logic [CW-1:0]                need;
    logic [AW-1:0]                emit_idx;
    logic [PKT_MAX-1:0][DW-1:0]   words;
    logic [CW-1:0]                len_in;
    logic                         hs_in;
    logic                         wr_en;
    logic [AW-1:0]                wr_idx;
    logic [7:0]                   fcmd;
    logic                         is_xfer;
    logic                         fire;
    logic                         xc_load;
    logic                         xc_empty;
    logic                         xc_last;
    logic                         emit_done;

    assign len_in    = CW'(param_count(in_data[DW-1 -: 8])) + CW'(1);
    assign hs_in     = in_valid && in_ready;
    assign fcmd      = words[0][DW-1 -: 8];
    assign is_xfer   = (fcmd == CMD_VRAM_WR) || (fcmd == CMD_VRAM_RD);
    assign fire      = (state == ST_FRAME);
    assign xc_load   = fire && fcmd == CMD_VRAM_WR;
    assign wr_en     = hs_in && (state == ST_IDLE || state == ST_GATHER);
    assign wr_idx    = (state == ST_IDLE) ? '0 : AW'(held);
    assign emit_done = pkt_ready && (CW'(emit_idx) == need - CW'(1));

    gpp_pkt_store #(.DW(DW), .DEPTH(PKT_MAX)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (in_data),
        .words_o (words)
    );

    gpp_side_fx #(.DW(DW), .ENV_N(ENV_N), .ST_W(ST_W)) u_fx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .word0    (words[0]),
        .word4_lo (words[4][8:0]),
        .word5_lo (words[5][8:0]),
        .status_o (status_bits),
        .env_o    (env_regs)
    );

    gpp_xfer_ctrl #(.XFER_W(XFER_W)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_word (words[2]),
        .load      (xc_load),
        .step      (xfer_wvalid && xfer_wready),
        .empty_o   (xc_empty),
        .last_o    (xc_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (hs_in) begin
                    state_nx = (len_in == CW'(1)) ? ST_FRAME : ST_GATHER;
                end
            end
            ST_GATHER: begin
                if (hs_in && held + CW'(1) == need) begin
                    state_nx = ST_FRAME;
                end
            end
            ST_FRAME: begin
                if (!is_xfer) begin
                    state_nx = ST_EMIT;
                end else if (fcmd == CMD_VRAM_WR && !xc_empty) begin
                    state_nx = ST_XFER;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            ST_EMIT: begin
                if (emit_done) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_XFER: begin
                if (hs_in && xc_last) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Packet bookkeeping counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held     <= '0;
            need     <= '0;
            emit_idx <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (hs_in) begin
                        held <= CW'(1);
                        need <= len_in;
                    end
                end
                ST_GATHER: begin
                    if (hs_in) begin
                        held <= held + CW'(1);
                    end
                end
                ST_FRAME: emit_idx <= '0;
                ST_EMIT: begin
                    if (pkt_ready) begin
                        emit_idx <= emit_idx + AW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        in_ready    = 1'b0;
        pkt_valid   = 1'b0;
        pkt_data    = words[emit_idx];
        pkt_first   = (emit_idx == '0);
        pkt_last    = (CW'(emit_idx) == need - CW'(1));
        dirty_mark  = 1'b0;
        xfer_start  = 1'b0;
        xfer_read   = (fcmd == CMD_VRAM_RD);
        xfer_pos    = words[1];
        xfer_size   = words[2];
        xfer_wvalid = 1'b0;
        xfer_wdata  = in_data;
        xfer_wlast  = xc_last;
        unique case (state)
            ST_IDLE, ST_GATHER: in_ready = 1'b1;
            ST_FRAME: begin
                dirty_mark = (fcmd >= 8'h02) && (fcmd <= 8'hBF);
                xfer_start = is_xfer;
            end
            ST_EMIT: pkt_valid = 1'b1;
            ST_XFER: begin
                in_ready    = xfer_wready;
                xfer_wvalid = in_valid;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/gpp_cmd_parser_chk.sv
module gpp_cmd_parser_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               in_ready,
    input logic               pkt_valid,
    input logic               pkt_ready,
    input logic [31:0]        pkt_data,
    input logic               pkt_first,
    input logic               pkt_last,
    input logic               dirty_mark,
    input logic               xfer_start,
    input logic               xfer_wvalid,
    input logic [12:0]        status_bits,
    input logic [255:0]       env_regs,
    input gpp_pkg::state_e    state
);
    import gpp_pkg::*;

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (status_bits == '0 && env_regs == '0 && !pkt_valid));

    // R4
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)
                                       && $stable(pkt_first) && $stable(pkt_last)));

    // R4
    no_accept_while_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !in_ready);

    // R5
    status_only_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FRAME) |=> $stable(status_bits));

    // R7
    env_only_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FRAME) |=> $stable(env_regs));

    // R8
    dirty_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_mark |=> !dirty_mark);

    // R9
    start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R9
    start_not_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !pkt_valid);

    // R10
    wdata_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_wvalid |-> !pkt_valid);

endmodule

bind gpp_cmd_parser gpp_cmd_parser_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .pkt_valid   (pkt_valid),
    .pkt_ready   (pkt_ready),
    .pkt_data    (pkt_data),
    .pkt_first   (pkt_first),
    .pkt_last    (pkt_last),
    .dirty_mark  (dirty_mark),
    .xfer_start  (xfer_start),
    .xfer_wvalid (xfer_wvalid),
    .status_bits (status_bits),
    .env_regs    (env_regs),
    .state       (state)
);

// File: tb/tb_gpp_cmd_parser.sv
module tb_gpp_cmd_parser;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_data = '0;
    logic         pkt_valid;
    logic         pkt_ready = 1'b1;
    logic [31:0]  pkt_data;
    logic         pkt_first, pkt_last;
    logic         dirty_mark;
    logic         xfer_start, xfer_read;
    logic [31:0]  xfer_pos, xfer_size;
    logic         xfer_wvalid;
    logic         xfer_wready = 1'b1;
    logic [31:0]  xfer_wdata;
    logic         xfer_wlast;
    logic [12:0]  status_bits;
    logic [255:0] env_regs;

    always #4 clk = ~clk;

    gpp_cmd_parser dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
        .pkt_first(pkt_first), .pkt_last(pkt_last),
        .dirty_mark(dirty_mark),
        .xfer_start(xfer_start), .xfer_read(xfer_read),
        .xfer_pos(xfer_pos), .xfer_size(xfer_size),
        .xfer_wvalid(xfer_wvalid), .xfer_wready(xfer_wready),
        .xfer_wdata(xfer_wdata), .xfer_wlast(xfer_wlast),
        .status_bits(status_bits), .env_regs(env_regs)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    // Capture monitors, sampled at the active edge before any update.
    logic [31:0] cap_data [0:255];
    logic        cap_first [0:255];
    logic        cap_last [0:255];
    int          cap_n = 0;
    logic [31:0] xw_data [0:63];
    logic        xw_last [0:63];
    int          xw_n = 0;
    int          dirty_n = 0;
    int          xs_n = 0;
    logic [31:0] xs_pos, xs_size;
    logic        xs_read;

    always @(posedge clk) begin
        if (rst_n) begin
            if (pkt_valid && pkt_ready && cap_n < 256) begin
                cap_data[cap_n]  <= pkt_data;
                cap_first[cap_n] <= pkt_first;
                cap_last[cap_n]  <= pkt_last;
                cap_n <= cap_n + 1;
            end
            if (xfer_wvalid && xfer_wready && xw_n < 64) begin
                xw_data[xw_n] <= xfer_wdata;
                xw_last[xw_n] <= xfer_wlast;
                xw_n <= xw_n + 1;
            end
            if (dirty_mark) dirty_n <= dirty_n + 1;
            if (xfer_start) begin
                xs_n    <= xs_n + 1;
                xs_pos  <= xfer_pos;
                xs_size <= xfer_size;
                xs_read <= xfer_read;
            end
        end
    end

    logic [31:0] pw [0:15];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
    endtask

    task automatic drop();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic send_pw(input int n);
        for (int k = 0; k < n; k++) push(pw[k]);
        drop();
    endtask

    task automatic check_fwd(input int base, input int n, input string req);
        settle(n + 4);
        chk(cap_n == base + n, req, "forwarded word count", 32'(cap_n - base), 32'(n));
        for (int k = 0; k < n; k++) begin
            if (base + k < 256) begin
                chk(cap_data[base + k] == pw[k], req, "forwarded word", cap_data[base + k], pw[k]);
                chk(cap_first[base + k] == (k == 0), req, "first flag", 32'(cap_first[base + k]), 32'(k == 0));
                chk(cap_last[base + k] == (k == n - 1), req, "last flag", 32'(cap_last[base + k]), 32'(k == n - 1));
            end
        end
    endtask

    task automatic fill_pkt(input logic [7:0] cmd, input int n);
        pw[0] = {cmd, 24'h000100};
        for (int k = 1; k < 16; k++) pw[k] = 32'h5A00_0000 | (32'(k) << 12);
        if (n < 1) pw[0] = pw[0];
    endtask

    task automatic t_reset();
        settle(1);
        chk(in_ready == 1'b1, "R1", "in_ready", 32'(in_ready), 32'd1);
        chk(!pkt_valid && !xfer_start && !xfer_wvalid, "R1", "outputs idle",
            32'({pkt_valid, xfer_start, xfer_wvalid}), 32'd0);
        chk(status_bits == '0, "R1", "status", 32'(status_bits), 32'd0);
        chk(env_regs == '0, "R1", "env zero", env_regs[31:0], 32'd0);
    endtask

    task automatic t_lengths();
        logic [7:0] cmds [0:13];
        int         lens [0:13];
        int         dirt [0:13];
        cmds = '{8'h00, 8'h01, 8'h02, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30,
                 8'h34, 8'h38, 8'h3C, 8'h80, 8'h23, 8'h3F};
        lens = '{1, 1, 3, 4, 7, 5, 9, 6, 9, 8, 12, 4, 4, 12};
        dirt = '{0, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1};
        for (int i = 0; i < 14; i++) begin
            int base = cap_n;
            int d0 = dirty_n;
            fill_pkt(cmds[i], lens[i]);
            send_pw(lens[i]);
            check_fwd(base, lens[i], "R2");
            chk(dirty_n - d0 == dirt[i], "R8", "dirty pulses", 32'(dirty_n - d0), 32'(dirt[i]));
        end
        chk(status_bits == '0, "R5", "status kept with zero low bits", 32'(status_bits), 32'd0);
    endtask

    task automatic t_gap();
        int base = cap_n;
        fill_pkt(8'h20, 4);
        push(pw[0]); push(pw[1]); drop();
        settle(20);
        chk(cap_n == base && !pkt_valid, "R3", "nothing forwarded mid packet", 32'(cap_n - base), 32'd0);
        push(pw[2]); drop(); settle(5);
        chk(cap_n == base, "R3", "still held", 32'(cap_n - base), 32'd0);
        push(pw[3]); drop();
        check_fwd(base, 4, "R3");
    endtask

    task automatic t_stall();
        int base = cap_n;
        fill_pkt(8'h28, 5);
        pkt_ready = 1'b0;
        send_pw(5);
        settle(6);
        chk(pkt_valid == 1'b1, "R4", "valid held", 32'(pkt_valid), 32'd1);
        chk(pkt_data == pw[0] && pkt_first, "R4", "word held", pkt_data, pw[0]);
        chk(in_ready == 1'b0, "R4", "input blocked", 32'(in_ready), 32'd0);
        @(negedge clk);
        pkt_ready = 1'b1;
        @(negedge clk);
        pkt_ready = 1'b0;
        settle(3);
        chk(pkt_data == pw[1] && !pkt_first, "R4", "second word held", pkt_data, pw[1]);
        pkt_ready = 1'b1;
        check_fwd(base, 5, "R4");
    endtask

    task automatic t_status();
        logic [12:0] exp_st;
        int base;
        exp_st = status_bits;
        pw[0] = 32'hE100_0ABC; send_pw(1); settle(4);
        exp_st[10:0] = 11'h2BC;
        chk(status_bits == exp_st, "R6", "E1 update", 32'(status_bits), 32'(exp_st));
        pw[0] = 32'hE600_0003; send_pw(1); settle(4);
        exp_st[12:11] = 2'b11;
        chk(status_bits == exp_st, "R6", "E6 update", 32'(status_bits), 32'(exp_st));
        base = cap_n;
        fill_pkt(8'h26, 7);
        pw[4] = 32'hFFFF_F155; pw[5] = 32'h0000_0033;
        send_pw(7);
        check_fwd(base, 7, "R5");
        exp_st[8:0] = 9'h155;
        chk(status_bits == exp_st, "R5", "flat textured word 4", 32'(status_bits), 32'(exp_st));
        base = cap_n;
        fill_pkt(8'h35, 9);
        pw[4] = 32'h0000_01FF; pw[5] = 32'h1234_50AA;
        send_pw(9);
        check_fwd(base, 9, "R5");
        exp_st[8:0] = 9'h0AA;
        chk(status_bits == exp_st, "R5", "shaded textured word 5", 32'(status_bits), 32'(exp_st));
    endtask

    task automatic t_env();
        int d0 = dirty_n;
        pw[0] = 32'hE312_3456; send_pw(1);
        pw[0] = 32'hE0AB_CDEF; send_pw(1);
        pw[0] = 32'hE7FE_DCBA; send_pw(1);
        settle(4);
        chk(env_regs[3*32 +: 32] == 32'hE312_3456, "R7", "env 3", env_regs[3*32 +: 32], 32'hE312_3456);
        chk(env_regs[0 +: 32] == 32'hE0AB_CDEF, "R7", "env 0", env_regs[0 +: 32], 32'hE0AB_CDEF);
        chk(env_regs[7*32 +: 32] == 32'hE7FE_DCBA, "R7", "env 7", env_regs[7*32 +: 32], 32'hE7FE_DCBA);
        chk(env_regs[5*32 +: 32] == 32'h0, "R7", "env 5 untouched", env_regs[5*32 +: 32], 32'h0);
        chk(env_regs[6*32 +: 32] == 32'hE600_0003, "R7", "env 6 from earlier", env_regs[6*32 +: 32], 32'hE600_0003);
        chk(dirty_n == d0, "R8", "no dirty for E range", 32'(dirty_n - d0), 32'd0);
    endtask

    task automatic t_write(input logic [31:0] size, input int nwords);
        int base = cap_n;
        int xb = xw_n;
        int s0 = xs_n;
        int d0 = dirty_n;
        push(32'hA000_0000); push(32'h0010_0020); push(size); drop();
        settle(3);
        chk(xs_n == s0 + 1, "R9", "write start pulse", 32'(xs_n - s0), 32'd1);
        chk(xs_pos == 32'h0010_0020 && xs_size == size, "R9", "write pos/size", xs_size, size);
        chk(xs_read == 1'b0, "R9", "write direction", 32'(xs_read), 32'd0);
        chk(dirty_n == d0 + 1, "R8", "write marks dirty", 32'(dirty_n - d0), 32'd1);
        for (int k = 0; k < nwords; k++) push(32'hD000_0000 + 32'(k));
        pw[0] = 32'h0000_0077;
        push(pw[0]); drop();
        settle(5);
        chk(xw_n - xb == nwords, "R10", "routed word count", 32'(xw_n - xb), 32'(nwords));
        for (int k = 0; k < nwords; k++) begin
            chk(xw_data[xb + k] == 32'hD000_0000 + 32'(k), "R10", "routed data",
                xw_data[xb + k], 32'hD000_0000 + 32'(k));
            chk(xw_last[xb + k] == (k == nwords - 1), "R10", "wlast",
                32'(xw_last[xb + k]), 32'(k == nwords - 1));
        end
        chk(cap_n == base + 1 && cap_data[base] == pw[0], "R10", "parsing resumes",
            cap_data[base], pw[0]);
    endtask

    task automatic t_read();
        int base = cap_n;
        int s0 = xs_n;
        int d0 = dirty_n;
        int xb = xw_n;
        push(32'hC000_0000); push(32'h0003_0004); push(32'h0004_0004);
        pw[0] = 32'h0100_0055;
        push(pw[0]); drop();
        settle(5);
        chk(xs_n == s0 + 1 && xs_read == 1'b1, "R9", "read start", 32'(xs_read), 32'd1);
        chk(xs_pos == 32'h0003_0004, "R9", "read pos", xs_pos, 32'h0003_0004);
        chk(dirty_n == d0, "R8", "read not dirty", 32'(dirty_n - d0), 32'd0);
        chk(xw_n == xb, "R11", "no write data", 32'(xw_n - xb), 32'd0);
        chk(cap_n == base + 1 && cap_data[base] == pw[0], "R11", "next word is a command",
            cap_data[base], pw[0]);
    endtask

    initial begin
        settle(4);
        rst_n = 1'b1;
        t_reset();
        t_lengths();
        t_gap();
        t_stall();
        t_status();
        t_env();
        t_write(32'h0002_0003, 3);
        t_write(32'h0001_0003, 2);
        t_write(32'h0000_0005, 0);
        t_read();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule